// File: doc/BRIEF.md
# Trace Waypoint Protocol Checker

This block is a passive monitor on the interface that carries waypoint records from a processor core to its trace unit. On every clock edge where the valid strobe is high, it examines the waypoint kind, the link and taken flags, the target address with its instruction-set state bits, the trace-prohibited flag, the exception code and the source address. It reports every rule those fields break. The block never drives or alters the interface.

Each rule has its own sticky error bit. The bits are cleared together by a synchronous clear input. A one-cycle pulse marks every waypoint that breaks at least one rule. The checker keeps two pieces of state across cycles: whether a debug session is open, and whether trace is currently prohibited. A reset-exception waypoint discards both. The block also counts the valid waypoints it has checked, so a testbench or an on-chip monitor can confirm that records reached it.

Waypoint kind codes used throughout: 000 direct branch, 001 indirect branch, 010 exception, 011 barrier, 100 debug entry or trace prohibited, 101 debug exit. Codes 110 and 111 are illegal.

Top module: `wp_proto_chk`

## Requirements
- R1: A valid waypoint whose kind is 110 or 111 sets error bit 0.
- R2: A valid waypoint with the link flag high sets error bit 1 unless its kind is 000 or 001.
- R3: A valid waypoint with the taken flag low sets error bit 2 unless its kind is 000 or 001.
- R4: A valid waypoint of kind 100 with a nonzero target address sets error bit 3.
- R5: A valid waypoint sets error bit 4 if target bit 1 is high while the target T bit is low, or if target bit 0 is high while the target J bit is low.
- R6: A valid waypoint with trace-prohibited high and either the target T bit or the target J bit high sets error bit 5.
- R7: A valid waypoint with trace-prohibited high sets error bit 6 if the previous valid waypoint also had trace-prohibited high and was not a reset exception.
- R8: Error bit 7 is set by a debug entry (kind 100 with trace-prohibited low) while a debug session is open, and by a debug exit (kind 101) while no session is open. An entry opens a session; an exit closes it.
- R9: An exception waypoint (kind 010) with exception code 1000 (reset) and a nonzero source address sets error bit 8. Any reset-exception waypoint closes the debug session and clears the prohibited state.
- R10: Error bits reset to zero and stay set until the clear input. The clear empties all bits, but a violation in the same cycle as the clear is still recorded.
- R11: The error pulse is high for exactly the cycle after each violating waypoint, which is the same cycle its error bit first appears. The pulse is low otherwise.
- R12: When the valid strobe is low, no field is checked and neither the error bits nor the state change.
- R13: The waypoint count resets to zero, increments once per valid cycle, and the clear sets it to the valid strobe of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of error bits and count |
| valid_i | input | 1 | Waypoint valid strobe |
| kind_i | input | 3 | Waypoint kind code |
| link_i | input | 1 | Branch updates link register |
| taken_i | input | 1 | Waypoint passed its condition |
| tgt_pc_i | input | AW | Target address |
| tgt_t_i | input | 1 | Target T state bit |
| tgt_j_i | input | 1 | Target J state bit |
| prohib_i | input | 1 | Trace prohibited at target |
| exc_code_i | input | 4 | Exception code |
| src_pc_i | input | AW | Last executed address |
| err_o | output | 9 | Sticky per-rule error bits |
| err_pulse_o | output | 1 | Violation pulse |
| wp_count_o | output | CW | Checked waypoint count |

## Verification
The single-waypoint rules are tested with a sweep over every kind code, both link and taken values, all four T/J combinations, and four target patterns: zero, bit 0 only, bit 1 only, and an aligned nonzero value. Together these patterns separate the alignment rule from the zero-target rule and keep branches apart from the other kinds. Each swept waypoint starts from fresh state, so only the first-exit case reaches the pairing rule. The temporal rules are tested with directed sequences: a repeated entry against entry-exit-entry, a repeated prohibit against prohibit-resume-prohibit, and a reset exception placed between the two halves of each pair. Idle cycles carrying illegal fields, and a clear that coincides with a violation, test the reporting paths.

// File: rtl/wp_chk_pkg.sv
package wp_chk_pkg;
  localparam logic [2:0] K_DBR   = 3'b000;
  localparam logic [2:0] K_IBR   = 3'b001;
  localparam logic [2:0] K_EXC   = 3'b010;
  localparam logic [2:0] K_BAR   = 3'b011;
  localparam logic [2:0] K_DENT  = 3'b100;
  localparam logic [2:0] K_DEXIT = 3'b101;
  localparam logic [3:0] EXC_RST = 4'b1000;

  localparam int NRULE   = 9;
  localparam int E_KIND  = 0;
  localparam int E_LINK  = 1;
  localparam int E_TAKEN = 2;
  localparam int E_TGTZ  = 3;
  localparam int E_ALIGN = 4;
  localparam int E_PSTB  = 5;
  localparam int E_PREP  = 6;
  localparam int E_PAIR  = 7;
  localparam int E_RSRC  = 8;

  typedef logic [NRULE-1:0] rule_vec_t;
endpackage

// File: rtl/wp_state_trk.sv
module wp_state_trk
  import wp_chk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [2:0] kind_i,
  input  logic       prohib_i,
  input  logic [3:0] exc_code_i,
  output logic       in_dbg_o,
  output logic       prohib_st_o
);
  logic rst_exc;
  logic in_dbg_q, prohib_q;

  assign rst_exc = (kind_i == K_EXC) && (exc_code_i == EXC_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_dbg_q <= 1'b0;
      prohib_q <= 1'b0;
    end else if (valid_i) begin
      prohib_q <= prohib_i && !rst_exc;
      if (rst_exc)
        in_dbg_q <= 1'b0;
      else if (kind_i == K_DENT && !prohib_i)
        in_dbg_q <= 1'b1;
      else if (kind_i == K_DEXIT)
        in_dbg_q <= 1'b0;
    end
  end

  assign in_dbg_o    = in_dbg_q;
  assign prohib_st_o = prohib_q;
endmodule

// File: rtl/wp_rule_eval.sv
module wp_rule_eval
  import wp_chk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          valid_i,
  input  logic [2:0]    kind_i,
  input  logic          link_i,
  input  logic          taken_i,
  input  logic [AW-1:0] tgt_pc_i,
  input  logic          tgt_t_i,
  input  logic          tgt_j_i,
  input  logic          prohib_i,
  input  logic [3:0]    exc_code_i,
  input  logic [AW-1:0] src_pc_i,
  input  logic          in_dbg_i,
  input  logic          prohib_st_i,
  output rule_vec_t     viol_o
);
  logic is_br, is_entry, is_exit;

  assign is_br    = (kind_i[2:1] == 2'b00);
  assign is_entry = (kind_i == K_DENT) && !prohib_i;
  assign is_exit  = (kind_i == K_DEXIT);

  always_comb begin
    viol_o = '0;
    if (valid_i) begin
      viol_o[E_KIND]  = (kind_i[2:1] == 2'b11);
      viol_o[E_LINK]  = link_i && !is_br;
      viol_o[E_TAKEN] = !taken_i && !is_br;
      viol_o[E_TGTZ]  = (kind_i == K_DENT) && (tgt_pc_i != '0);
      viol_o[E_ALIGN] = (!tgt_t_i && tgt_pc_i[1]) || (!tgt_j_i && tgt_pc_i[0]);
      viol_o[E_PSTB]  = prohib_i && (tgt_t_i || tgt_j_i);
      viol_o[E_PREP]  = prohib_i && prohib_st_i;
      viol_o[E_PAIR]  = (is_entry && in_dbg_i) || (is_exit && !in_dbg_i);
      viol_o[E_RSRC]  = (kind_i == K_EXC) && (exc_code_i == EXC_RST) && (src_pc_i != '0);
    end
  end
endmodule

// File: rtl/wp_err_log.sv
module wp_err_log
  import wp_chk_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          valid_i,
  input  rule_vec_t     viol_i,
  output rule_vec_t     err_o,
  output logic          err_pulse_o,
  output logic [CW-1:0] count_o
);
  rule_vec_t     err_q;
  logic          pulse_q;
  logic [CW-1:0] cnt_q;

  for (genvar g = 0; g < NRULE; g++) begin : g_sticky
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          err_q[g] <= 1'b0;
      else if (viol_i[g])   err_q[g] <= 1'b1;
      else if (clr_i)       err_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pulse_q <= |viol_i;
      if (clr_i)        cnt_q <= CW'(valid_i);
      else if (valid_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign err_o       = err_q;
  assign err_pulse_o = pulse_q;
  assign count_o     = cnt_q;
endmodule

// File: rtl/wp_proto_chk.sv
module wp_proto_chk
  import wp_chk_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          valid_i,
  input  logic [2:0]    kind_i,
  input  logic          link_i,
  input  logic          taken_i,
  input  logic [AW-1:0] tgt_pc_i,
  input  logic          tgt_t_i,
  input  logic          tgt_j_i,
  input  logic          prohib_i,
  input  logic [3:0]    exc_code_i,
  input  logic [AW-1:0] src_pc_i,
  output logic [8:0]    err_o,
  output logic          err_pulse_o,
  output logic [CW-1:0] wp_count_o
);
  logic      in_dbg, prohib_st;
  rule_vec_t viol;

  wp_state_trk i_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .kind_i     (kind_i),
    .prohib_i   (prohib_i),
    .exc_code_i (exc_code_i),
    .in_dbg_o   (in_dbg),
    .prohib_st_o(prohib_st)
  );

  wp_rule_eval #(.AW(AW)) i_rules (
    .valid_i    (valid_i),
    .kind_i     (kind_i),
    .link_i     (link_i),
    .taken_i    (taken_i),
    .tgt_pc_i   (tgt_pc_i),
    .tgt_t_i    (tgt_t_i),
    .tgt_j_i    (tgt_j_i),
    .prohib_i   (prohib_i),
    .exc_code_i (exc_code_i),
    .src_pc_i   (src_pc_i),
    .in_dbg_i   (in_dbg),
    .prohib_st_i(prohib_st),
    .viol_o     (viol)
  );

  wp_err_log #(.CW(CW)) i_log (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .valid_i    (valid_i),
    .viol_i     (viol),
    .err_o      (err_o),
    .err_pulse_o(err_pulse_o),
    .count_o    (wp_count_o)
  );
endmodule

// File: rtl/wp_proto_chk_sva.sv
module wp_proto_chk_sva #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          valid_i,
  input logic [2:0]    kind_i,
  input logic          link_i,
  input logic          taken_i,
  input logic [AW-1:0] tgt_pc_i,
  input logic          tgt_t_i,
  input logic          tgt_j_i,
  input logic          prohib_i,
  input logic [8:0]    err_o,
  input logic          err_pulse_o,
  input logic [CW-1:0] wp_count_o
);
  a_r1_bad_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i[2:1] == 2'b11 |=> err_o[0] && err_pulse_o);

  a_r2_link_nonbranch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && link_i && kind_i[2:1] != 2'b00 |=> err_o[1]);

  a_r3_taken_missing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !taken_i && kind_i[2:1] != 2'b00 |=> err_o[2]);

  a_r6_prohib_tbits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && prohib_i && (tgt_t_i || tgt_j_i) |=> err_o[5]);

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (err_o & $past(err_o)) == $past(err_o));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !valid_i |=> err_o == '0);

  a_r11_pulse_has_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> err_o != '0);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !clr_i |=> $stable(err_o) && !err_pulse_o && $stable(wp_count_o));

  a_r13_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !clr_i |=> wp_count_o == $past(wp_count_o) + 1'b1);

  wire unused_ok = |tgt_pc_i;
endmodule

bind wp_proto_chk wp_proto_chk_sva #(.AW(AW), .CW(CW)) i_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .valid_i    (valid_i),
  .kind_i     (kind_i),
  .link_i     (link_i),
  .taken_i    (taken_i),
  .tgt_pc_i   (tgt_pc_i),
  .tgt_t_i    (tgt_t_i),
  .tgt_j_i    (tgt_j_i),
  .prohib_i   (prohib_i),
  .err_o      (err_o),
  .err_pulse_o(err_pulse_o),
  .wp_count_o (wp_count_o)
);

// File: tb/test_wp_proto_chk.sv
`timescale 1ns/1ps
module test_wp_proto_chk;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr, valid, link, taken, t_b, j_b, prohib;
  logic [2:0]    kind;
  logic [AW-1:0] tgt, src;
  logic [3:0]    exc;
  logic [8:0]    err;
  logic          pulse;
  logic [CW-1:0] cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wp_proto_chk #(.AW(AW), .CW(CW)) i_wp_proto_chk (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .valid_i(valid), .kind_i(kind),
    .link_i(link), .taken_i(taken), .tgt_pc_i(tgt), .tgt_t_i(t_b), .tgt_j_i(j_b),
    .prohib_i(prohib), .exc_code_i(exc), .src_pc_i(src),
    .err_o(err), .err_pulse_o(pulse), .wp_count_o(cnt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(logic c, logic v, logic [2:0] k, logic l, logic tk,
                      logic [AW-1:0] tp, logic tt, logic jj, logic p,
                      logic [3:0] e, logic [AW-1:0] s);
    @(negedge clk);
    clr = c; valid = v; kind = k; link = l; taken = tk; tgt = tp;
    t_b = tt; j_b = jj; prohib = p; exc = e; src = s;
    @(posedge clk);
    #1;
  endtask

  task automatic do_clr();  step(1, 0, 3'd0, 0, 1, '0, 0, 0, 0, 4'd0, '0); endtask
  task automatic rst_exc(); step(0, 1, 3'd2, 0, 1, '0, 0, 0, 0, 4'd8, '0); endtask
  task automatic entry();   step(0, 1, 3'd4, 0, 1, '0, 0, 0, 0, 4'd0, '0); endtask
  task automatic dexit();   step(0, 1, 3'd5, 0, 1, '0, 0, 0, 0, 4'd0, '0); endtask
  task automatic prohibit(); step(0, 1, 3'd4, 0, 1, '0, 0, 0, 1, 4'd0, '0); endtask

  function automatic string req_of(logic [8:0] d);
    if (d[0]) return "R1";
    if (d[1]) return "R2";
    if (d[2]) return "R3";
    if (d[3]) return "R4";
    if (d[4]) return "R5";
    if (d[7]) return "R8";
    return "R11";
  endfunction

  initial begin
    clr = 0; valid = 0; kind = 0; link = 0; taken = 0; tgt = '0;
    t_b = 0; j_b = 0; prohib = 0; exc = 0; src = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset err", 32'(err), 0);
    check("R11 reset pulse", 32'(pulse), 0);
    check("R13 reset count", 32'(cnt), 0);
    @(negedge clk); rst_n = 1'b1;

    // single-waypoint sweep, fresh state each time
    for (int k = 0; k < 8; k++)
      for (int l = 0; l < 2; l++)
        for (int tk = 0; tk < 2; tk++)
          for (int tj = 0; tj < 4; tj++)
            for (int tp = 0; tp < 4; tp++) begin
              logic [AW-1:0] a;
              logic [8:0] m;
              logic tt, jj;
              a  = (tp == 0) ? '0 : (tp == 1) ? 32'h1 : (tp == 2) ? 32'h2 : 32'h100;
              tt = tj[0]; jj = tj[1];
              m = '0;
              m[0] = (k >= 6);
              m[1] = l[0] && (k > 1);
              m[2] = !tk[0] && (k > 1);
              m[3] = (k == 4) && (a != 0);
              m[4] = (!tt && a[1]) || (!jj && a[0]);
              m[7] = (k == 5);
              do_clr();
              step(0, 1, 3'(k), l[0], tk[0], a, tt, jj, 0, 4'd0, '0);
              if ({pulse, err} !== {(m != 0), m})
                check(req_of(err ^ m), {22'd0, pulse, err}, {22'd0, (m != 0), m});
              else
                check("R1", 0, 0);
              rst_exc();
            end

    // R8 pairing
    do_clr(); rst_exc(); entry();
    check("R8 first entry", 32'(err), 0);
    entry();
    check("R8 double entry", 32'(err), 32'h80);
    do_clr(); rst_exc(); entry(); dexit(); entry();
    check("R8 entry exit entry", 32'(err), 0);

    // R7 prohibit repetition
    do_clr(); rst_exc(); prohibit();
    check("R7 first prohibit", 32'(err), 0);
    prohibit();
    check("R7 repeated prohibit", 32'(err), 32'h40);
    do_clr(); rst_exc(); prohibit();
    step(0, 1, 3'd0, 0, 0, '0, 0, 0, 0, 4'd0, '0);
    prohibit();
    check("R7 prohibit after resume", 32'(err), 0);

    // R6 prohibit with state bits
    do_clr(); rst_exc();
    step(0, 1, 3'd4, 0, 1, '0, 1, 0, 1, 4'd0, '0);
    check("R6 prohibit with T", 32'(err), 32'h20);
    do_clr(); rst_exc();
    step(0, 1, 3'd4, 0, 1, '0, 0, 1, 1, 4'd0, '0);
    check("R6 prohibit with J", 32'(err), 32'h20);

    // R9 reset exception clears state and checks source
    do_clr(); rst_exc(); entry(); rst_exc(); entry();
    check("R9 reset closes debug", 32'(err), 0);
    do_clr(); rst_exc(); prohibit(); rst_exc(); prohibit();
    check("R9 reset clears prohibit", 32'(err), 0);
    do_clr();
    step(0, 1, 3'd2, 0, 1, '0, 0, 0, 0, 4'd8, 32'h4);
    check("R9 reset source nonzero", 32'(err), 32'h100);
    do_clr();
    step(0, 1, 3'd2, 0, 1, '0, 0, 0, 0, 4'd9, 32'h4);
    check("R9 other exception source", 32'(err), 0);

    // R12 idle with garbage fields
    do_clr(); rst_exc();
    step(0, 0, 3'd7, 1, 0, 32'h3, 0, 0, 1, 4'd8, 32'h4);
    check("R12 idle err", 32'(err), 0);
    check("R12 idle pulse", 32'(pulse), 0);
    check("R12 idle count", 32'(cnt), 1);
    prohibit();
    check("R12 idle kept no prohibit state", 32'(err), 0);

    // R10/R11 sticky and pulse timing
    do_clr();
    step(0, 1, 3'd6, 0, 1, '0, 0, 0, 0, 4'd0, '0);
    check("R11 pulse on violation", 32'(pulse), 1);
    rst_exc();
    check("R10 sticky after good", 32'(err), 1);
    check("R11 pulse drops", 32'(pulse), 0);
    step(1, 1, 3'd7, 0, 1, '0, 0, 0, 0, 4'd0, '0);
    check("R10 clear with violation", 32'(err), 1);
    do_clr();
    check("R10 clear empties", 32'(err), 0);

    // R13 count
    for (int i = 0; i < 5; i++) rst_exc();
    check("R13 count five", 32'(cnt), 5);
    step(1, 1, 3'd2, 0, 1, '0, 0, 0, 0, 4'd8, '0);
    check("R13 clear with valid", 32'(cnt), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule